// File: doc/BRIEF.md
# Precise Exception Commit Unit

This block tracks exception conditions for every instruction in a five-stage in-order pipeline and acts on them only when the instruction reaches the memory stage, which is the commit point. An instruction enters with its fetch address and an optional fetch-address fault. A tag then travels alongside it. The decode stage can add an illegal-opcode or system-call condition to the tag. The execute stage can add an arithmetic overflow, and the memory stage a data-address fault. The first condition recorded for an instruction is the one that is kept.

At the commit point the unit decides whether the instruction retires or traps. An external interrupt request is honoured there when interrupts are enabled, and it takes precedence over any synchronous condition. When a trap is taken, the unit does the following in the same cycle:

- asserts kill strobes for fetch, decode, execute and writeback;
- redirects fetch to a fixed handler address;
- on the next clock edge, stores the exception PC and a cause code, masks interrupts and enters kernel mode.

A return-from-exception instruction that commits cleanly unmasks interrupts and returns to user mode.

Top module: `prex_commit_unit`

## Requirements
- R1: While reset is held low and in the first cycle after it, the kill, redirect and commit outputs are low, `epc` and `cause` are zero, `intEnable` is 0 and `kernelMode` is 1.
- R2: An instruction presented at fetch in cycle t reaches the commit point in cycle t+3. A condition raised for it in any stage causes no kill or redirect before that cycle.
- R3: For one instruction, the condition from the earliest stage is kept. Fetch fault (cause 1) beats decode conditions. Within decode, illegal opcode (cause 2) beats system call (cause 5). Decode conditions beat overflow (cause 3), which beats data-address fault (cause 4).
- R4: An interrupt request while `intEnable` is 1 and a valid instruction is at commit traps with cause 0 and saves that instruction's PC, overriding any synchronous condition. While `intEnable` is 0 the request has no effect.
- R5: In the commit cycle of a trap, `killFetch`, `killDecode`, `killExecute`, `killWriteback` and `redirectValid` are all 1 and `redirectPc` equals the handler address. None of the three younger instructions ever commits.
- R6: `epc` and `cause` change only on the clock edge that ends a trap's commit cycle. `epc` receives the instruction's PC, or that PC plus 4 when the kept cause is system call (5).
- R7: After a trap, `intEnable` is 0 and `kernelMode` is 1.
- R8: A return-from-exception instruction (flagged by `decRfe` while it is in decode) that commits without a trap sets `intEnable` to 1 and `kernelMode` to 0 from the next cycle.
- R9: A stage holding a bubble ignores its fault inputs, and a bubble at the commit point never traps.
- R10: `commitValid` is 1 exactly when a valid instruction is at the commit point and no trap is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | An instruction is presented at fetch this cycle |
| fetchPc | input | PC_W | Address of the fetched instruction |
| fetchFault | input | 1 | Fetch address fault for the fetched instruction |
| decIllegal | input | 1 | Instruction in decode has an illegal opcode |
| decSyscall | input | 1 | Instruction in decode is a system call |
| decRfe | input | 1 | Instruction in decode is a return-from-exception |
| exeOverflow | input | 1 | Instruction in execute overflowed |
| memAddrFault | input | 1 | Instruction at commit has a data address fault |
| irqReq | input | 1 | External interrupt request, level |
| killFetch | output | 1 | Discard the instruction in fetch |
| killDecode | output | 1 | Discard the instruction in decode |
| killExecute | output | 1 | Discard the instruction in execute |
| killWriteback | output | 1 | Suppress writeback of the committing instruction |
| commitValid | output | 1 | Committing instruction retires normally |
| redirectValid | output | 1 | Fetch must restart at `redirectPc` |
| redirectPc | output | PC_W | Handler address |
| epc | output | PC_W | Saved exception PC |
| cause | output | 3 | Saved cause code |
| intEnable | output | 1 | Interrupts enabled |
| kernelMode | output | 1 | Privileged mode |

## Verification
The case that needs care is an enabled interrupt arriving in the same cycle that a system call, or another instruction with a synchronous condition, reaches commit. It is provoked directly, with the request raised exactly in the commit cycle of such an instruction. It is also provoked at random, with interrupt, return and fault inputs toggled densely while a bench model tracks every stage. The result is judged on the saved cause, which must be 0. It is also judged on the saved PC, which must be the instruction's own address rather than the following one. A second collision is a return-from-exception committing while an interrupt is pending. The request must be ignored in that cycle and honoured at the next valid commit.

// File: rtl/prex_pkg.sv
package prex_pkg;

  localparam int CAUSE_W = 3;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_IRQ     = 3'd0,
    CAUSE_FETCH   = 3'd1,
    CAUSE_ILLEGAL = 3'd2,
    CAUSE_OVF     = 3'd3,
    CAUSE_DATA    = 3'd4,
    CAUSE_SYSCALL = 3'd5
  } causeE;

  // Tag carried alongside each in-flight instruction
  typedef struct packed {
    logic  valid;
    logic  excPending;
    causeE cause;
    logic  rfe;
  } stageTagT;

  // Strobes from control to datapath
  typedef struct packed {
    logic  takeExc;
    logic  takeRfe;
    logic  useNextPc;
    logic  commitOk;
    causeE cause;
  } ctrlStrobeT;

endpackage

// File: rtl/prex_stage.sv
module prex_stage
  import prex_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            flush,
  input  stageTagT        inTag,
  input  logic [PC_W-1:0] inPc,
  input  logic            localFault,
  input  causeE           localCause,
  input  logic            localRfe,
  output stageTagT        outTag,
  output logic [PC_W-1:0] outPc
);

  stageTagT        heldTag;
  logic [PC_W-1:0] heldPc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldTag <= '0;
      heldPc  <= '0;
    end else if (flush) begin
      heldTag <= '0;
    end else begin
      heldTag <= inTag;
      heldPc  <= inPc;
    end
  end

  // First recorded condition wins; bubbles ignore local inputs
  always_comb begin
    outTag = heldTag;
    if (heldTag.valid && !heldTag.excPending && localFault) begin
      outTag.excPending = 1'b1;
      outTag.cause      = localCause;
    end
    if (heldTag.valid && localRfe) begin
      outTag.rfe = 1'b1;
    end
  end

  assign outPc = heldPc;

endmodule

// File: rtl/prex_datapath.sv
module prex_datapath
  import prex_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            fetchValid,
  input  logic [PC_W-1:0] fetchPc,
  input  logic            fetchFault,
  input  logic            decIllegal,
  input  logic            decSyscall,
  input  logic            decRfe,
  input  logic            exeOverflow,
  input  logic            memAddrFault,
  input  ctrlStrobeT      strobe,
  output stageTagT        commitTag,
  output logic [PC_W-1:0] epcQ,
  output causeE           causeQ,
  output logic            intEnableQ,
  output logic            kernelModeQ
);

  localparam int NUM_STAGES = 3;  // decode, execute, memory

  stageTagT        tagChain   [NUM_STAGES+1];
  logic [PC_W-1:0] pcChain    [NUM_STAGES+1];
  logic            stageFault [NUM_STAGES];
  causeE           stageCause [NUM_STAGES];
  logic            stageRfe   [NUM_STAGES];

  assign tagChain[0] = '{valid:      fetchValid,
                         excPending: fetchValid & fetchFault,
                         cause:      CAUSE_FETCH,
                         rfe:        1'b0};
  assign pcChain[0]  = fetchPc;

  assign stageFault[0] = decIllegal | decSyscall;
  assign stageCause[0] = decIllegal ? CAUSE_ILLEGAL : CAUSE_SYSCALL;
  assign stageRfe[0]   = decRfe;
  assign stageFault[1] = exeOverflow;
  assign stageCause[1] = CAUSE_OVF;
  assign stageRfe[1]   = 1'b0;
  assign stageFault[2] = memAddrFault;
  assign stageCause[2] = CAUSE_DATA;
  assign stageRfe[2]   = 1'b0;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    prex_stage #(.PC_W(PC_W)) stage_i (
      .clk       (clk),
      .rstN      (rstN),
      .flush     (strobe.takeExc),
      .inTag     (tagChain[s]),
      .inPc      (pcChain[s]),
      .localFault(stageFault[s]),
      .localCause(stageCause[s]),
      .localRfe  (stageRfe[s]),
      .outTag    (tagChain[s+1]),
      .outPc     (pcChain[s+1])
    );
  end

  assign commitTag = tagChain[NUM_STAGES];

  logic [PC_W-1:0] commitPc;
  logic [PC_W-1:0] savePc;
  assign commitPc = pcChain[NUM_STAGES];
  assign savePc   = strobe.useNextPc ? commitPc + PC_W'(INSN_BYTES) : commitPc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      epcQ        <= '0;
      causeQ      <= CAUSE_IRQ;
      intEnableQ  <= 1'b0;
      kernelModeQ <= 1'b1;
    end else if (strobe.takeExc) begin
      epcQ        <= savePc;
      causeQ      <= strobe.cause;
      intEnableQ  <= 1'b0;
      kernelModeQ <= 1'b1;
    end else if (strobe.takeRfe) begin
      intEnableQ  <= 1'b1;
      kernelModeQ <= 1'b0;
    end
  end

endmodule

// File: rtl/prex_control.sv
module prex_control
  import prex_pkg::*;
(
  input  stageTagT   commitTag,
  input  logic       irqReq,
  input  logic       intEnable,
  output ctrlStrobeT strobe
);

  logic irqTake;
  logic trap;

  assign irqTake = commitTag.valid && irqReq && intEnable;
  assign trap    = commitTag.valid && (irqTake || commitTag.excPending);

  always_comb begin
    strobe.takeExc   = trap;
    strobe.cause     = irqTake ? CAUSE_IRQ : commitTag.cause;
    strobe.useNextPc = !irqTake && (commitTag.cause == CAUSE_SYSCALL);
    strobe.takeRfe   = commitTag.valid && commitTag.rfe && !trap;
    strobe.commitOk  = commitTag.valid && !trap;
  end

endmodule

// File: rtl/prex_commit_unit.sv
module prex_commit_unit
  import prex_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter int              INSN_BYTES = 4,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0180
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            fetchValid,
  input  logic [PC_W-1:0] fetchPc,
  input  logic            fetchFault,
  input  logic            decIllegal,
  input  logic            decSyscall,
  input  logic            decRfe,
  input  logic            exeOverflow,
  input  logic            memAddrFault,
  input  logic            irqReq,
  output logic            killFetch,
  output logic            killDecode,
  output logic            killExecute,
  output logic            killWriteback,
  output logic            commitValid,
  output logic            redirectValid,
  output logic [PC_W-1:0] redirectPc,
  output logic [PC_W-1:0] epc,
  output logic [2:0]      cause,
  output logic            intEnable,
  output logic            kernelMode
);

  ctrlStrobeT strobe;
  stageTagT   commitTag;
  causeE      causeQ;

  prex_datapath #(.PC_W(PC_W), .INSN_BYTES(INSN_BYTES)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .fetchValid  (fetchValid),
    .fetchPc     (fetchPc),
    .fetchFault  (fetchFault),
    .decIllegal  (decIllegal),
    .decSyscall  (decSyscall),
    .decRfe      (decRfe),
    .exeOverflow (exeOverflow),
    .memAddrFault(memAddrFault),
    .strobe      (strobe),
    .commitTag   (commitTag),
    .epcQ        (epc),
    .causeQ      (causeQ),
    .intEnableQ  (intEnable),
    .kernelModeQ (kernelMode)
  );

  prex_control ctl_i (
    .commitTag(commitTag),
    .irqReq   (irqReq),
    .intEnable(intEnable),
    .strobe   (strobe)
  );

  assign killFetch     = strobe.takeExc;
  assign killDecode    = strobe.takeExc;
  assign killExecute   = strobe.takeExc;
  assign killWriteback = strobe.takeExc;
  assign redirectValid = strobe.takeExc;
  assign redirectPc    = HANDLER_PC;
  assign commitValid   = strobe.commitOk;
  assign cause         = causeQ;

endmodule

// File: rtl/prex_checker.sv
module prex_checker #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            irqReq,
  input logic            redirectValid,
  input logic            commitValid,
  input logic            intEnable,
  input logic            kernelMode,
  input logic [PC_W-1:0] epc,
  input logic [2:0]      cause
);

  assert_trap_masks_R7: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |=> (kernelMode && !intEnable));

  assert_younger_discarded_R5: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |=> (!commitValid && !redirectValid));

  assert_irq_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    (redirectValid && irqReq && intEnable) |=> (cause == 3'd0));

  assert_irq_not_missed_R4: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |-> !(irqReq && intEnable));

  assert_state_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !redirectValid |=> ($stable(epc) && $stable(cause)));

  assert_rfe_unmask_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intEnable) |-> ($past(commitValid) && !kernelMode));

endmodule

bind prex_commit_unit prex_checker #(.PC_W(PC_W)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .irqReq       (irqReq),
  .redirectValid(redirectValid),
  .commitValid  (commitValid),
  .intEnable    (intEnable),
  .kernelMode   (kernelMode),
  .epc          (epc),
  .cause        (cause)
);

// File: tb/prex_commit_unit_tb_top.sv
module prex_commit_unit_tb_top;

  localparam logic [31:0] HANDLER = 32'h0000_0180;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchValid = 0, fetchFault = 0, decIllegal = 0, decSyscall = 0;
  logic        decRfe = 0, exeOverflow = 0, memAddrFault = 0, irqReq = 0;
  logic [31:0] fetchPc = '0;
  logic        killFetch, killDecode, killExecute, killWriteback;
  logic        commitValid, redirectValid, intEnable, kernelMode;
  logic [31:0] redirectPc, epc;
  logic [2:0]  cause;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  prex_commit_unit #(.PC_W(32), .INSN_BYTES(4), .HANDLER_PC(HANDLER)) dut_i (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchPc(fetchPc),
    .fetchFault(fetchFault), .decIllegal(decIllegal), .decSyscall(decSyscall),
    .decRfe(decRfe), .exeOverflow(exeOverflow), .memAddrFault(memAddrFault),
    .irqReq(irqReq), .killFetch(killFetch), .killDecode(killDecode),
    .killExecute(killExecute), .killWriteback(killWriteback),
    .commitValid(commitValid), .redirectValid(redirectValid),
    .redirectPc(redirectPc), .epc(epc), .cause(cause),
    .intEnable(intEnable), .kernelMode(kernelMode)
  );

  // Bench model: index 0 decode, 1 execute, 2 commit
  bit          mv [3];
  bit          mexc [3];
  int          mcs [3];
  bit          mrfe [3];
  logic [31:0] mpc [3];
  logic [31:0] mEpc = '0;
  int          mCause = 0;
  bit          mIe = 0;
  bit          mKm = 1;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int pickCause(input bit ill);
    return ill ? 2 : 5;
  endfunction

  task automatic step(input bit fv, input logic [31:0] pc, input bit ff,
                      input bit ill, input bit sys, input bit rfe,
                      input bit ovf, input bit df, input bit irq);
    bit rexc [3];
    int rcs [3];
    bit rrfe [3];
    bit irqT, take;
    int expCause;
    logic [31:0] expEpc;
    @(negedge clk);
    fetchValid = fv; fetchPc = pc; fetchFault = ff; decIllegal = ill;
    decSyscall = sys; decRfe = rfe; exeOverflow = ovf; memAddrFault = df;
    irqReq = irq;
    #1;
    for (int s = 0; s < 3; s++) begin
      rexc[s] = mexc[s]; rcs[s] = mcs[s]; rrfe[s] = mrfe[s];
    end
    if (mv[0] && !rexc[0] && (ill || sys)) begin rexc[0] = 1; rcs[0] = pickCause(ill); end
    if (mv[0] && rfe) rrfe[0] = 1;
    if (mv[1] && !rexc[1] && ovf) begin rexc[1] = 1; rcs[1] = 3; end
    if (mv[2] && !rexc[2] && df) begin rexc[2] = 1; rcs[2] = 4; end
    irqT = mv[2] && irq && mIe;
    take = mv[2] && (irqT || rexc[2]);
    expCause = irqT ? 0 : rcs[2];
    expEpc = (!irqT && rcs[2] == 5) ? mpc[2] + 4 : mpc[2];

    chk("R2/R5/R9", "redirectValid", 32'(redirectValid), 32'(take));
    chk("R5", "killFetch", 32'(killFetch), 32'(take));
    chk("R5", "killDecode", 32'(killDecode), 32'(take));
    chk("R5", "killExecute", 32'(killExecute), 32'(take));
    chk("R5", "killWriteback", 32'(killWriteback), 32'(take));
    if (take) chk("R5", "redirectPc", redirectPc, HANDLER);
    chk("R9/R10", "commitValid", 32'(commitValid), 32'(mv[2] && !take));
    chk("R6", "epc", epc, mEpc);
    chk("R3/R4/R6", "cause", 32'(cause), 32'(mCause));
    chk("R7/R8", "intEnable", 32'(intEnable), 32'(mIe));
    chk("R7/R8", "kernelMode", 32'(kernelMode), 32'(mKm));

    if (take) begin
      mEpc = expEpc; mCause = expCause; mIe = 0; mKm = 1;
      for (int s = 0; s < 3; s++) begin
        mv[s] = 0; mexc[s] = 0; mrfe[s] = 0; mcs[s] = 0;
      end
    end else begin
      if (mv[2] && rrfe[2]) begin mIe = 1; mKm = 0; end
      mv[2] = mv[1]; mpc[2] = mpc[1]; mexc[2] = rexc[1]; mcs[2] = rcs[1]; mrfe[2] = rrfe[1];
      mv[1] = mv[0]; mpc[1] = mpc[0]; mexc[1] = rexc[0]; mcs[1] = rcs[0]; mrfe[1] = rrfe[0];
      mv[0] = fv; mpc[0] = pc; mexc[0] = fv && ff; mcs[0] = 1; mrfe[0] = 0;
    end
  endtask

  task automatic idle(input int n, input bit irq);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0, 0, 0, 0, irq);
  endtask

  // One instruction: fetch fault, decode ill/sys/rfe, overflow, data fault, irq at commit
  task automatic oneInsn(input logic [31:0] pc, input bit ff, input bit ill,
                         input bit sys, input bit rfe, input bit ovf,
                         input bit df, input bit irq);
    step(1, pc, ff, 0, 0, 0, 0, 0, 0);
    step(0, '0, 0, ill, sys, rfe, 0, 0, 0);
    step(0, '0, 0, 0, 0, 0, ovf, 0, 0);
    step(0, '0, 0, 0, 0, 0, 0, df, irq);
    step(0, '0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int s = 0; s < 3; s++) begin
      mv[s] = 0; mexc[s] = 0; mcs[s] = 0; mrfe[s] = 0; mpc[s] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "redirectValid", 32'(redirectValid), 0);
    chk("R1", "commitValid", 32'(commitValid), 0);
    chk("R1", "intEnable", 32'(intEnable), 0);
    chk("R1", "kernelMode", 32'(kernelMode), 1);
    chk("R1", "epc", epc, 0);
    chk("R1", "cause", 32'(cause), 0);
    rstN = 1'b1;

    // R4: interrupt ignored while masked
    oneInsn(32'h100, 0, 0, 0, 0, 0, 0, 1);
    // R8: return unmasks
    oneInsn(32'h104, 0, 0, 0, 1, 0, 0, 0);
    // R4: interrupt collides with syscall at commit, cause 0, epc = pc
    oneInsn(32'h200, 0, 0, 1, 0, 0, 0, 1);
    oneInsn(32'h204, 0, 0, 0, 1, 0, 0, 0);
    // R6: syscall alone saves pc+4
    oneInsn(32'h300, 0, 0, 1, 0, 0, 0, 0);
    // R3: all faults on one instruction keep fetch fault
    oneInsn(32'h400, 1, 1, 1, 0, 1, 1, 0);
    // R3: illegal beats syscall, overflow beats data fault
    oneInsn(32'h500, 0, 1, 1, 0, 1, 1, 0);
    oneInsn(32'h600, 0, 0, 0, 0, 1, 1, 0);
    // R9: bubbles with faults never trap
    idle(4, 0);
    step(0, '0, 0, 1, 1, 0, 1, 1, 0);
    idle(3, 0);
    // R5: back-to-back instructions, oldest traps, younger discarded
    step(1, 32'h700, 0, 0, 0, 0, 0, 0, 0);
    step(1, 32'h704, 0, 1, 0, 0, 0, 0, 0);
    step(1, 32'h708, 1, 0, 0, 0, 0, 0, 0);
    step(1, 32'h70c, 0, 0, 0, 0, 1, 0, 0);
    idle(4, 0);

    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 4) != 0, $urandom & 32'hFFFF_FFFC,
           ($urandom % 24) == 0, ($urandom % 20) == 0, ($urandom % 16) == 0,
           ($urandom % 5) == 0, ($urandom % 20) == 0, ($urandom % 24) == 0,
           ($urandom % 6) == 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule